// File: doc/BRIEF.md
# Multi-core lock queue controller

This block is the shared mutex and thread-placement service for a cluster of processor cores. Every core has its own request port and can ask for one of four services: take the lock of an object address, give a lock back, place a new thread, or report that one of its threads has ended. A fixed-priority arbiter picks one pending request per cycle, and the block serves it in that same cycle. The acknowledge and any response show up on the registered outputs one cycle later.

Locks live in a lock table whose entries are found by object address. Each occupied entry points to a linked list of waiting records in a second table, and each record holds a core index and a thread tag. The record at the head of the list owns the lock, and new requesters join at the tail. When the owner releases the lock, its record is unlinked and the next record in the list is granted the lock. New threads go to the core that has the fewest live threads, according to a per-core counter table.

A core raises its valid line with an opcode, an address and a thread tag. It holds them until its acknowledge bit pulses, then drops the valid line.

Top module: `mlq_lock_queue`

## Requirements
- R1: A request is taken from the eligible core with the lowest index. At most one is served per cycle. The core's `ack_o` bit pulses for exactly one cycle, on the clock after the request was sampled. A request still held during its acknowledge cycle is not served a second time. After reset all outputs are zero.
- R2: The opcode encoding is 0 = acquire, 1 = release, 2 = place a new thread, 3 = thread exit. Each core's opcode sits at bits [2c+1:2c] of `req_op_i`, its address at `req_addr_i[AW*c +: AW]`, and its tag at `req_tid_i[TW*c +: TW]`.
- R3: An acquire of an address that no lock holds makes the requester the owner. In the acknowledge cycle, `grant_vld_o` is one-hot on the requesting core and `grant_tid_o` carries its tag.
- R4: An acquire of a held address appends the requester to that lock's waiting list with no grant. Waiters later receive the lock in the order they arrived.
- R5: A release by the owner removes the owner. If a waiter remains, that waiter's core gets a one-cycle grant carrying its tag in the acknowledge cycle. If none remains, the lock entry is freed and no grant is issued.
- R6: A release of an unheld address, or by a core/tag pair that is not the owner, pulses `err_o` and changes no lock state.
- R7: The lock table holds 16 entries and the waiting table holds 32. An acquire that needs a new entry in a full table pulses `busy_o` and is not queued.
- R8: Placing a thread pulses `disp_vld_o`, and `disp_core_o` names the core with the lowest live-thread count, with ties going to the lowest index. That core's count is then incremented, saturating at its maximum.
- R9: A thread-exit request decrements the requesting core's count. The count does not go below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld_i | input | NCORES | Per-core request valid |
| req_op_i | input | 2*NCORES | Per-core opcode |
| req_addr_i | input | AW*NCORES | Per-core object address |
| req_tid_i | input | TW*NCORES | Per-core thread tag |
| ack_o | output | NCORES | One-cycle acknowledge to the served core |
| grant_vld_o | output | NCORES | One-cycle ownership grant to a core |
| grant_tid_o | output | TW | Tag of the thread being granted |
| busy_o | output | 1 | Table full, acquire refused |
| err_o | output | 1 | Release by a non-owner or of an unheld lock |
| disp_vld_o | output | 1 | New-thread placement valid |
| disp_core_o | output | CIW | Core chosen for the new thread |

## Verification
A corrupted list link or head pointer does not show up at once. It shows up at the next release of that lock, which grants the wrong core or tag, skips a waiter, or raises `err_o` against the real owner. A wrong free-entry choice shows up as an early or missing `busy_o` when the tables fill. A thread counter that drifts shows up only on the next placement, as the wrong `disp_core_o`. For this reason the bench compares every output on every cycle against a behavioural queue model and drives release chains and full-table cases to expose these faults within a few requests.

// File: rtl/mlq_pkg.sv
package mlq_pkg;

    typedef enum logic [1:0] {
        OP_ACQ  = 2'd0,
        OP_REL  = 2'd1,
        OP_DISP = 2'd2,
        OP_EXIT = 2'd3
    } mlq_op_e;

endpackage

// File: rtl/mlq_arbiter.sv
module mlq_arbiter #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    // Scan from the top so the lowest index is the one left standing.
    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
                idx_o    = IW'(i);
                any_o    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mlq_least_loaded.sv
module mlq_least_loaded #(
    parameter int N  = 4,
    parameter int CW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][CW-1:0] cnt_i,
    output logic [IW-1:0]        idx_o
);

    logic [IW-1:0] best;

    // Strict less-than keeps the lower index on equal counts.
    always_comb begin
        best = '0;
        for (int i = 1; i < N; i++) begin
            if (cnt_i[i] < cnt_i[best]) best = IW'(i);
        end
        idx_o = best;
    end

endmodule

// File: rtl/mlq_thread_counts.sv
module mlq_thread_counts #(
    parameter int N  = 4,
    parameter int CW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    input  logic [IW-1:0] dec_idx_i,
    output logic [IW-1:0] min_idx_o
);

    logic [N-1:0][CW-1:0] cnt_q, cnt_d;

    mlq_least_loaded #(.N(N), .CW(CW)) u_min (
        .cnt_i (cnt_q),
        .idx_o (min_idx_o)
    );

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q[min_idx_o] != {CW{1'b1}}))
            cnt_d[min_idx_o] = cnt_q[min_idx_o] + 1'b1;
        if (dec_i && (cnt_q[dec_idx_i] != '0))
            cnt_d[dec_idx_i] = cnt_q[dec_idx_i] - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: only one request is served per cycle, so the two never coincide
    p_single_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_i && dec_i));

    // R8: placement bumps the chosen counter on the next edge
    p_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && cnt_q[min_idx_o] != {CW{1'b1}}) |=>
        cnt_q[$past(min_idx_o)] == $past(cnt_q[min_idx_o]) + 1'b1);

    // R9: exit on a zero counter leaves it at zero
    p_dec_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && cnt_q[dec_idx_i] == '0) |=> cnt_q[$past(dec_idx_i)] == '0);

    for (genvar g = 0; g < N; g++) begin : g_min_chk
        // R8: no core is lighter than the pick, and a tie never favours a higher index
        p_least_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(cnt_q[g] < cnt_q[min_idx_o]) &&
            !((cnt_q[g] == cnt_q[min_idx_o]) && (int'(min_idx_o) > g)));
    end

endmodule

// File: rtl/mlq_lock_queue.sv
module mlq_lock_queue
    import mlq_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int AW     = 32,
    parameter int TW     = 8,
    parameter int LOCKS  = 16,
    parameter int WAITS  = 32,
    parameter int CW     = 8,
    localparam int CIW = (NCORES > 1) ? $clog2(NCORES) : 1,
    localparam int LIW = (LOCKS > 1) ? $clog2(LOCKS) : 1,
    localparam int WIW = (WAITS > 1) ? $clog2(WAITS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCORES-1:0]    req_vld_i,
    input  logic [2*NCORES-1:0]  req_op_i,
    input  logic [AW*NCORES-1:0] req_addr_i,
    input  logic [TW*NCORES-1:0] req_tid_i,
    output logic [NCORES-1:0]    ack_o,
    output logic [NCORES-1:0]    grant_vld_o,
    output logic [TW-1:0]        grant_tid_o,
    output logic                 busy_o,
    output logic                 err_o,
    output logic                 disp_vld_o,
    output logic [CIW-1:0]       disp_core_o
);

    typedef struct packed {
        logic [NCORES-1:0]           ack;
        logic [NCORES-1:0]           gvld;
        logic [TW-1:0]               gtid;
        logic                        busy;
        logic                        err;
        logic                        dvld;
        logic [CIW-1:0]              dcore;
        logic [LOCKS-1:0]            lk_vld;
        logic [LOCKS-1:0][AW-1:0]    lk_addr;
        logic [LOCKS-1:0][WIW-1:0]   lk_head;
        logic [LOCKS-1:0][WIW-1:0]   lk_tail;
        logic [WAITS-1:0]            wt_vld;
        logic [WAITS-1:0][CIW-1:0]   wt_core;
        logic [WAITS-1:0][TW-1:0]    wt_tid;
        logic [WAITS-1:0][WIW-1:0]   wt_next;
    } state_t;

    state_t st_q, st_d;

    // ---------------- arbitration ----------------
    logic [NCORES-1:0] elig;
    logic [NCORES-1:0] sel_oh;
    logic [CIW-1:0]    sel_idx;
    logic              sel_any;

    // A core seen in its acknowledge cycle is masked so a held line is served once.
    assign elig = req_vld_i & ~st_q.ack;

    mlq_arbiter #(.N(NCORES)) u_arb (
        .req_i (elig),
        .gnt_o (sel_oh),
        .idx_o (sel_idx),
        .any_o (sel_any)
    );

    mlq_op_e          cur_op;
    logic [AW-1:0]    cur_addr;
    logic [TW-1:0]    cur_tid;

    assign cur_op   = mlq_op_e'(req_op_i[int'(sel_idx)*2 +: 2]);
    assign cur_addr = req_addr_i[int'(sel_idx)*AW +: AW];
    assign cur_tid  = req_tid_i[int'(sel_idx)*TW +: TW];

    // ---------------- thread counters ----------------
    logic           cnt_inc, cnt_dec;
    logic [CIW-1:0] min_idx;

    mlq_thread_counts #(.N(NCORES), .CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (cnt_inc),
        .dec_i     (cnt_dec),
        .dec_idx_i (sel_idx),
        .min_idx_o (min_idx)
    );

    // ---------------- table lookups ----------------
    logic           hit;
    logic [LIW-1:0] hit_idx;
    logic           lk_fr_ok;
    logic [LIW-1:0] lk_fr;
    logic           wt_fr_ok;
    logic [WIW-1:0] wt_fr;

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        lk_fr_ok = 1'b0;
        lk_fr    = '0;
        for (int i = 0; i < LOCKS; i++) begin
            if (!hit && st_q.lk_vld[i] && (st_q.lk_addr[i] == cur_addr)) begin
                hit     = 1'b1;
                hit_idx = LIW'(i);
            end
            if (!lk_fr_ok && !st_q.lk_vld[i]) begin
                lk_fr_ok = 1'b1;
                lk_fr    = LIW'(i);
            end
        end
    end

    always_comb begin
        wt_fr_ok = 1'b0;
        wt_fr    = '0;
        for (int j = 0; j < WAITS; j++) begin
            if (!wt_fr_ok && !st_q.wt_vld[j]) begin
                wt_fr_ok = 1'b1;
                wt_fr    = WIW'(j);
            end
        end
    end

    logic [WIW-1:0] head_rec;
    logic [WIW-1:0] next_rec;
    logic           owner_match;

    assign head_rec    = st_q.lk_head[hit_idx];
    assign next_rec    = st_q.wt_next[head_rec];
    assign owner_match = hit && (st_q.wt_core[head_rec] == sel_idx)
                             && (st_q.wt_tid[head_rec] == cur_tid);

    // ---------------- next state ----------------
    always_comb begin
        st_d       = st_q;
        st_d.ack   = '0;
        st_d.gvld  = '0;
        st_d.gtid  = '0;
        st_d.busy  = 1'b0;
        st_d.err   = 1'b0;
        st_d.dvld  = 1'b0;
        st_d.dcore = '0;
        cnt_inc    = 1'b0;
        cnt_dec    = 1'b0;
        if (sel_any) begin
            st_d.ack = sel_oh;
            case (cur_op)
                OP_ACQ: begin
                    if (hit) begin
                        if (wt_fr_ok) begin
                            st_d.wt_vld[wt_fr]                  = 1'b1;
                            st_d.wt_core[wt_fr]                 = sel_idx;
                            st_d.wt_tid[wt_fr]                  = cur_tid;
                            st_d.wt_next[wt_fr]                 = '0;
                            st_d.wt_next[st_q.lk_tail[hit_idx]] = wt_fr;
                            st_d.lk_tail[hit_idx]               = wt_fr;
                        end else begin
                            st_d.busy = 1'b1;
                        end
                    end else if (lk_fr_ok && wt_fr_ok) begin
                        st_d.lk_vld[lk_fr]  = 1'b1;
                        st_d.lk_addr[lk_fr] = cur_addr;
                        st_d.lk_head[lk_fr] = wt_fr;
                        st_d.lk_tail[lk_fr] = wt_fr;
                        st_d.wt_vld[wt_fr]  = 1'b1;
                        st_d.wt_core[wt_fr] = sel_idx;
                        st_d.wt_tid[wt_fr]  = cur_tid;
                        st_d.wt_next[wt_fr] = '0;
                        st_d.gvld[sel_idx]  = 1'b1;
                        st_d.gtid           = cur_tid;
                    end else begin
                        st_d.busy = 1'b1;
                    end
                end
                OP_REL: begin
                    if (owner_match) begin
                        st_d.wt_vld[head_rec] = 1'b0;
                        if (head_rec == st_q.lk_tail[hit_idx]) begin
                            st_d.lk_vld[hit_idx] = 1'b0;
                        end else begin
                            st_d.lk_head[hit_idx]              = next_rec;
                            st_d.gvld[st_q.wt_core[next_rec]]  = 1'b1;
                            st_d.gtid                          = st_q.wt_tid[next_rec];
                        end
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
                OP_DISP: begin
                    cnt_inc    = 1'b1;
                    st_d.dvld  = 1'b1;
                    st_d.dcore = min_idx;
                end
                default: begin
                    cnt_dec = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_o       = st_q.ack;
    assign grant_vld_o = st_q.gvld;
    assign grant_tid_o = st_q.gtid;
    assign busy_o      = st_q.busy;
    assign err_o       = st_q.err;
    assign disp_vld_o  = st_q.dvld;
    assign disp_core_o = st_q.dcore;

    // ---------------- assertions ----------------
    p_ack_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    // R5: at most one core receives ownership per cycle
    p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vld_o));

    // R3: a grant always rides on an acknowledged request
    p_grant_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_vld_o) |-> (|ack_o));

    // R6: refusal and error are different outcomes of one request
    p_busy_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && err_o));

    // R8: placement result belongs to an acknowledged request
    p_disp_acked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld_o |-> (|ack_o));

    for (genvar k = 0; k < NCORES; k++) begin : g_core_chk
        localparam logic [NCORES-1:0] LOWER = NCORES'((1 << k) - 1);

        // R1: served core had a request last cycle
        p_ack_had_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ack_o[k] |-> $past(req_vld_i[k]));

        // R1: no eligible lower-index core was passed over
        p_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ack_o[k] |-> (($past(req_vld_i) & ~$past(ack_o) & LOWER) == '0));

        // R1: acknowledge never lasts two cycles
        p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ack_o[k] |=> !ack_o[k]);
    end

endmodule

// File: tb/mlq_lock_queue_tb_top.sv
`timescale 1ns/1ps
module mlq_lock_queue_tb_top;

    localparam int NC = 4;
    localparam int AW = 32;
    localparam int TW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     req_vld = '0;
    logic [2*NC-1:0]   req_op = '0;
    logic [AW*NC-1:0]  req_addr = '0;
    logic [TW*NC-1:0]  req_tid = '0;
    logic [NC-1:0]     ack_o;
    logic [NC-1:0]     grant_vld_o;
    logic [TW-1:0]     grant_tid_o;
    logic              busy_o;
    logic              err_o;
    logic              disp_vld_o;
    logic [1:0]        disp_core_o;

    always #2 clk = ~clk;

    mlq_lock_queue dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_vld_i   (req_vld),
        .req_op_i    (req_op),
        .req_addr_i  (req_addr),
        .req_tid_i   (req_tid),
        .ack_o       (ack_o),
        .grant_vld_o (grant_vld_o),
        .grant_tid_o (grant_tid_o),
        .busy_o      (busy_o),
        .err_o       (err_o),
        .disp_vld_o  (disp_vld_o),
        .disp_core_o (disp_core_o)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural model ----------------
    typedef struct {
        int addr;
        int core;
        int tid;
    } rec_t;

    rec_t m_q[$];
    int   m_cnt[NC];
    int   e_ack, e_gvld, e_gtid, e_busy, e_err, e_dvld, e_dcore;
    int   m_elig, m_sel, m_op, m_a, m_t, m_f, m_best;

    function automatic int first_of(int a);
        for (int i = 0; i < m_q.size(); i++)
            if (m_q[i].addr == a) return i;
        return -1;
    endfunction

    function automatic int distinct_addrs();
        int n = 0;
        for (int i = 0; i < m_q.size(); i++) begin
            bit seen = 0;
            for (int j = 0; j < i; j++)
                if (m_q[j].addr == m_q[i].addr) seen = 1;
            if (!seen) n++;
        end
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            for (int c = 0; c < NC; c++) m_cnt[c] = 0;
            e_ack = 0; e_gvld = 0; e_gtid = 0; e_busy = 0;
            e_err = 0; e_dvld = 0; e_dcore = 0;
        end else begin
            m_elig = int'(req_vld) & ~e_ack;
            e_ack = 0; e_gvld = 0; e_gtid = 0; e_busy = 0;
            e_err = 0; e_dvld = 0; e_dcore = 0;
            m_sel = -1;
            for (int c = NC - 1; c >= 0; c--)
                if (m_elig[c]) m_sel = c;
            if (m_sel >= 0) begin
                e_ack = 1 << m_sel;
                m_op  = int'(req_op[m_sel*2 +: 2]);
                m_a   = int'(req_addr[m_sel*AW +: AW]);
                m_t   = int'(req_tid[m_sel*TW +: TW]);
                case (m_op)
                    0: begin
                        m_f = first_of(m_a);
                        if (m_f >= 0) begin
                            if (m_q.size() < 32) m_q.push_back('{m_a, m_sel, m_t});
                            else e_busy = 1;
                        end else if (m_q.size() < 32 && distinct_addrs() < 16) begin
                            m_q.push_back('{m_a, m_sel, m_t});
                            e_gvld = 1 << m_sel;
                            e_gtid = m_t;
                        end else begin
                            e_busy = 1;
                        end
                    end
                    1: begin
                        m_f = first_of(m_a);
                        if (m_f >= 0 && m_q[m_f].core == m_sel && m_q[m_f].tid == m_t) begin
                            m_q.delete(m_f);
                            m_f = first_of(m_a);
                            if (m_f >= 0) begin
                                e_gvld = 1 << m_q[m_f].core;
                                e_gtid = m_q[m_f].tid;
                            end
                        end else begin
                            e_err = 1;
                        end
                    end
                    2: begin
                        m_best = 0;
                        for (int c = 1; c < NC; c++)
                            if (m_cnt[c] < m_cnt[m_best]) m_best = c;
                        e_dvld  = 1;
                        e_dcore = m_best;
                        if (m_cnt[m_best] < 255) m_cnt[m_best]++;
                    end
                    default: begin
                        if (m_cnt[m_sel] > 0) m_cnt[m_sel]--;
                    end
                endcase
            end
        end
    end

    // ---------------- per-cycle compare and monitors ----------------
    int last_gcore = -1, last_gtid = -1, n_grant = 0, n_err = 0, n_busy = 0;
    int ack_cnt0 = 0;
    int ack_seq[$];
    int disp_seq[$];

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 ack", int'(ack_o), e_ack);
            chk("R5 grant_vld", int'(grant_vld_o), e_gvld);
            if (e_gvld != 0) chk("R3 grant_tid", int'(grant_tid_o), e_gtid);
            chk("R7 busy", int'(busy_o), e_busy);
            chk("R6 err", int'(err_o), e_err);
            chk("R8 disp_vld", int'(disp_vld_o), e_dvld);
            if (e_dvld != 0) chk("R8 disp_core", int'(disp_core_o), e_dcore);
            for (int c = 0; c < NC; c++) begin
                if (ack_o[c]) ack_seq.push_back(c);
                if (grant_vld_o[c]) begin
                    last_gcore = c;
                    last_gtid  = int'(grant_tid_o);
                    n_grant++;
                end
            end
            if (ack_o[0]) ack_cnt0++;
            if (err_o) n_err++;
            if (busy_o) n_busy++;
            if (disp_vld_o) disp_seq.push_back(int'(disp_core_o));
        end
    end

    // ---------------- stimulus helpers ----------------
    // R2: opcode at [2c+1:2c], address and tag in per-core slices
    task automatic send(int c, int op, int a, int t);
        req_op[c*2 +: 2]     = op[1:0];
        req_addr[c*AW +: AW] = a;
        req_tid[c*TW +: TW]  = t[TW-1:0];
        req_vld[c]           = 1'b1;
    endtask

    task automatic wait_done();
        do begin
            @(negedge clk);
            req_vld = req_vld & ~ack_o;
        end while (req_vld != '0);
        @(posedge clk);
    endtask

    task automatic req1(int c, int op, int a, int t);
        @(negedge clk);
        send(c, op, a, t);
        wait_done();
    endtask

    localparam int LA = 32'h40;
    localparam int LB = 32'h44;

    initial begin
        int g0, e0, b0, a0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state of all outputs
        chk("R1 reset ack", int'(ack_o), 0);
        chk("R1 reset grant", int'(grant_vld_o), 0);
        chk("R1 reset flags", int'({busy_o, err_o, disp_vld_o}), 0);
        rst_n = 1'b1;
        @(posedge clk);

        // R3: free lock granted to requester
        req1(0, 0, LA, 5);
        chk("R3 grant core", last_gcore, 0);
        chk("R3 grant tag", last_gtid, 5);

        // R1, R4: simultaneous acquires; core1 first, both queued, no grant
        g0 = n_grant;
        @(negedge clk);
        send(1, 0, LA, 7);
        send(2, 0, LA, 9);
        wait_done();
        chk("R4 no grant to waiters", n_grant, g0);
        chk("R1 order first", ack_seq[ack_seq.size()-2], 1);
        chk("R1 order second", ack_seq[ack_seq.size()-1], 2);

        // R6: waiter releasing is not the owner
        e0 = n_err;
        req1(2, 1, LA, 9);
        chk("R6 non-owner err", n_err, e0 + 1);

        // R4, R5: owner release hands to first waiter, then second
        req1(0, 1, LA, 5);
        chk("R4 fifo first core", last_gcore, 1);
        chk("R4 fifo first tag", last_gtid, 7);
        req1(1, 1, LA, 7);
        chk("R4 fifo second core", last_gcore, 2);
        chk("R4 fifo second tag", last_gtid, 9);
        g0 = n_grant;
        req1(2, 1, LA, 9);
        chk("R5 empty release no grant", n_grant, g0);
        req1(3, 0, LA, 11);
        chk("R5 freed lock reacquired", last_gcore, 3);

        // R6: unheld address
        e0 = n_err;
        req1(1, 1, LB, 3);
        chk("R6 unheld err", n_err, e0 + 1);

        // R7: fill the lock table
        for (int i = 0; i < 15; i++) req1(0, 0, 100 + i, i);
        b0 = n_busy;
        req1(0, 0, 200, 1);
        chk("R7 lock table full", n_busy, b0 + 1);
        // R7: fill the waiting table
        for (int i = 0; i < 16; i++) req1(1, 0, LA, 20 + i);
        b0 = n_busy;
        req1(2, 0, LA, 50);
        chk("R7 wait table full", n_busy, b0 + 1);
        req1(3, 1, LA, 11);
        chk("R7 refused not queued", last_gcore, 1);
        chk("R7 next tag", last_gtid, 20);

        // R8: four placements at once land on cores 0..3
        @(negedge clk);
        for (int c = 0; c < NC; c++) send(c, 2, 0, 0);
        wait_done();
        for (int i = 0; i < 4; i++)
            chk("R8 spread", disp_seq[disp_seq.size()-4+i], i);

        // R9: exit on core1 makes it the lightest
        req1(1, 3, 0, 0);
        req1(3, 2, 0, 0);
        chk("R9 placement after exit", disp_seq[disp_seq.size()-1], 1);
        req1(2, 3, 0, 0);
        req1(2, 3, 0, 0);
        req1(0, 2, 0, 0);
        chk("R9 floor then placement", disp_seq[disp_seq.size()-1], 2);

        // R1: request held through its acknowledge cycle is served once
        a0 = ack_cnt0;
        @(negedge clk);
        send(0, 2, 0, 0);
        do @(negedge clk); while (!ack_o[0]);
        @(negedge clk);
        req_vld[0] = 1'b0;
        repeat (2) @(posedge clk);
        chk("R1 held served once", ack_cnt0, a0 + 1);

        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        checks++;
        fails++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule